// File: doc/BRIEF.md
# Secure OTP Overlay Controller

This block sits beside the command decoder of a flash-style memory and owns a small one-time-programmable identification area of 128 words. It watches write cycles for a three-cycle command sequence. Two fixed unlock writes come first. The third write carries the command code, which turns a secure overlay mode on or off, or locks the area permanently.

While the overlay mode is on, the normal array is switched off. Accesses that fall into one boot-sector window are redirected to the identification area. The window sits at the highest addresses for a top-boot build and at the lowest addresses for a bottom-boot build. The block drives the array selects, the remapped word address and a program-permit flag for the current access. It also reports the lock state on a single status bit, which a status read places on data bit 0.

The lock register stands in for a non-volatile cell. Only the power-on reset clears it. The hardware reset returns the block to normal array mode and leaves the lock untouched. All outputs other than `lock_q` are combinational from the registered mode state and the access inputs.

Top module: `otp_overlay_ctrl`

## Requirements
- R1: The writes 0xAA at command address 0x555, then 0x55 at 0x2AA, then 0x88 at any address turn secure mode on. This takes effect from the clock edge that samples the third write.
- R2: The same two unlock writes followed by 0x90 turn secure mode off, from the edge that samples the third write.
- R3: Any write that breaks the expected sequence returns the decoder to idle. A later code write without fresh unlock writes has no effect. Only the 11 low command-address bits are compared.
- R4: In secure mode, an access inside the window whose offset within the window is below 128 gives sel_otp=1, sel_main=0 and map_addr equal to the offset bits [6:0].
- R5: In secure mode, any other access gives sel_main=0, sel_otp=0, map_addr=0 and prog_ok=0.
- R6: In normal mode, sel_main=1, sel_otp=0, map_addr=0 and prog_ok equals acc_prog.
- R7: Unlock writes followed by 0x60 set lock_q, but only while secure mode is on. Outside secure mode this sequence leaves lock_q at 0.
- R8: For an identification-area access, prog_ok equals acc_prog while lock_q=0, and prog_ok is 0 once lock_q=1.
- R9: rst_n low at a clock edge turns secure mode off and clears a partly received sequence. It keeps lock_q.
- R10: por_n low at a clock edge clears secure mode, the decoder and lock_q.
- R11: With TOP_BOOT=1, the window is the top 2^WIN_AW words of the access space. With TOP_BOOT=0, it is the bottom 2^WIN_AW words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, synchronous, active low |
| por_n | input | 1 | Power-on reset, synchronous, active low, also clears the lock |
| cmd_we | input | 1 | Decoded write-cycle strobe |
| cmd_addr | input | 11 | Low word-address bits of the write cycle |
| cmd_data | input | 8 | Data byte of the write cycle |
| acc_addr | input | 20 | Word address of the current array access |
| acc_prog | input | 1 | The current access is a program or erase request |
| sel_main | output | 1 | Route the access to the normal array |
| sel_otp | output | 1 | Route the access to the identification area |
| map_addr | output | 7 | Word address within the identification area |
| prog_ok | output | 1 | The program or erase request is permitted |
| lock_q | output | 1 | Lock status, reported as data bit 0 |

## Verification
The mode and lock registers change at the clock edge that samples the third command write. The routing outputs react to acc_addr within the same cycle, with no register in that path. A reference model in the bench steps at each rising edge and is compared against both a top-boot and a bottom-boot instance 5 ns after that edge, once the registers have settled. Directed checks change acc_addr after a falling edge and sample a short time later, well before the next rising edge.

// File: rtl/otp_ovl_pkg.sv
// Package: shared types and command constants for the secure OTP overlay.
// Assumes the command decoder compares only the low CMD_AW address bits.
package otp_ovl_pkg;

    localparam int CMD_AW = 11;

    localparam logic [CMD_AW-1:0] UNLK_ADDR_A = 11'h555;
    localparam logic [CMD_AW-1:0] UNLK_ADDR_B = 11'h2AA;
    localparam logic [7:0]        UNLK_DATA_A = 8'hAA;
    localparam logic [7:0]        UNLK_DATA_B = 8'h55;
    localparam logic [7:0]        CODE_ENTER  = 8'h88;
    localparam logic [7:0]        CODE_EXIT   = 8'h90;
    localparam logic [7:0]        CODE_LOCK   = 8'h60;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_GOT1 = 2'd1,
        SEQ_GOT2 = 2'd2
    } seq_st_t;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_ENTER = 2'd1,
        OP_EXIT  = 2'd2,
        OP_LOCK  = 2'd3
    } ovl_op_t;

endpackage

// File: rtl/otp_cmd_seq.sv
// Module: otp_cmd_seq
// Tracks the two unlock writes and decodes the code on the third write
// into a single-cycle operation. Any write that does not match the expected
// step sends the tracker back to idle. Assumes cmd_we lasts one cycle per
// write cycle. srst_n is a synchronous active-low reset.
module otp_cmd_seq
    import otp_ovl_pkg::*;
(
    input  logic              clk,
    input  logic              srst_n,
    input  logic              we,
    input  logic [CMD_AW-1:0] addr,
    input  logic [7:0]        data,
    output ovl_op_t           op
);

    seq_st_t st_q;
    seq_st_t st_d;
    logic    hit_a;
    logic    hit_b;

    // Purpose: match the two unlock steps.
    always_comb begin
        hit_a = (addr == UNLK_ADDR_A) && (data == UNLK_DATA_A);
        hit_b = (addr == UNLK_ADDR_B) && (data == UNLK_DATA_B);
    end

    // Purpose: next tracker state and op decode for the current write.
    always_comb begin
        st_d = st_q;
        op   = OP_NONE;
        if (we) begin
            unique case (st_q)
                SEQ_IDLE: st_d = hit_a ? SEQ_GOT1 : SEQ_IDLE;
                SEQ_GOT1: st_d = hit_b ? SEQ_GOT2 : SEQ_IDLE;
                SEQ_GOT2: begin
                    st_d = SEQ_IDLE;
                    if (data == CODE_ENTER)     op = OP_ENTER;
                    else if (data == CODE_EXIT) op = OP_EXIT;
                    else if (data == CODE_LOCK) op = OP_LOCK;
                    else                        op = OP_NONE;
                end
                default:  st_d = SEQ_IDLE;
            endcase
        end
    end

    // Purpose: tracker state register.
    always_ff @(posedge clk) begin
        if (!srst_n) st_q <= SEQ_IDLE;
        else         st_q <= st_d;
    end

    // A broken second step must return to idle (R3).
    p_abort_second_r3: assert property (@(posedge clk) disable iff (!srst_n)
        (we && st_q == SEQ_GOT1 && !hit_b) |=> (st_q == SEQ_IDLE));

    // An op is only produced at the third step (R3).
    p_op_only_third_r3: assert property (@(posedge clk) disable iff (!srst_n)
        (op != OP_NONE) |-> (st_q == SEQ_GOT2));

endmodule

// File: rtl/otp_mode_lock.sv
// Module: otp_mode_lock
// Holds the secure-mode flag and the sticky lock bit. The hardware reset
// clears only the mode. The power-on reset clears both, since the lock
// stands in for a non-volatile cell. A lock op counts only in secure mode.
module otp_mode_lock
    import otp_ovl_pkg::*;
(
    input  logic    clk,
    input  logic    hw_rst_n,
    input  logic    por_n,
    input  ovl_op_t op,
    output logic    secure_q,
    output logic    lock_q
);

    // Purpose: secure-mode flag register.
    always_ff @(posedge clk) begin
        if (!por_n || !hw_rst_n)   secure_q <= 1'b0;
        else if (op == OP_ENTER)   secure_q <= 1'b1;
        else if (op == OP_EXIT)    secure_q <= 1'b0;
    end

    // Purpose: sticky lock register, cleared only at power-on.
    always_ff @(posedge clk) begin
        if (!por_n)                              lock_q <= 1'b0;
        else if (hw_rst_n && op == OP_LOCK && secure_q) lock_q <= 1'b1;
    end

    p_enter_r1: assert property (@(posedge clk) disable iff (!por_n || !hw_rst_n)
        (op == OP_ENTER) |=> secure_q);

    p_exit_r2: assert property (@(posedge clk) disable iff (!por_n || !hw_rst_n)
        (op == OP_EXIT) |=> !secure_q);

    p_lock_needs_secure_r7: assert property (@(posedge clk) disable iff (!por_n)
        (!secure_q && !lock_q) |=> !lock_q);

    p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!por_n)
        lock_q |=> lock_q);

    p_hwrst_mode_r9: assert property (@(posedge clk) disable iff (!por_n)
        !hw_rst_n |=> !secure_q);

endmodule

// File: rtl/otp_addr_map.sv
// Module: otp_addr_map
// Decodes an access address against the boot-sector window and routes it
// either to the normal array or to the identification area. TOP_BOOT picks
// a window at the top or at the bottom of the space. Assumes
// WIN_AW > OTP_AW and ADDR_W > WIN_AW.
module otp_addr_map #(
    parameter int ADDR_W    = 20,
    parameter int WIN_AW    = 15,
    parameter int OTP_WORDS = 128,
    parameter bit TOP_BOOT  = 1'b1,
    localparam int OTP_AW   = $clog2(OTP_WORDS)
) (
    input  logic              secure,
    input  logic              locked,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_prog,
    output logic              sel_main,
    output logic              sel_otp,
    output logic [OTP_AW-1:0] map_addr,
    output logic              prog_ok
);

    localparam int TAG_W = ADDR_W - WIN_AW;
    localparam int GAP_W = WIN_AW - OTP_AW;

    logic [TAG_W-1:0] tag;
    logic [GAP_W-1:0] gap;
    logic             in_win;
    logic             in_otp;

    assign tag = acc_addr[ADDR_W-1:WIN_AW];
    assign gap = acc_addr[WIN_AW-1:OTP_AW];

    // Purpose: choose the window position from the boot configuration.
    generate
        if (TOP_BOOT) begin : g_top
            assign in_win = &tag;
        end else begin : g_bot
            assign in_win = ~|tag;
        end
    endgenerate

    // Purpose: only the first OTP_WORDS words of the window are backed.
    assign in_otp = in_win && (gap == '0);

    // Purpose: route the access and decide whether programming is allowed.
    always_comb begin
        if (secure) begin
            sel_main = 1'b0;
            sel_otp  = in_otp;
            map_addr = in_otp ? acc_addr[OTP_AW-1:0] : '0;
            prog_ok  = acc_prog && in_otp && !locked;
        end else begin
            sel_main = 1'b1;
            sel_otp  = 1'b0;
            map_addr = '0;
            prog_ok  = acc_prog;
        end
    end

endmodule

// File: rtl/otp_overlay_ctrl.sv
// Module: otp_overlay_ctrl (top)
// Ties the command tracker, the mode/lock registers and the address router
// together. Both resets are synchronous and active low. The hardware reset
// clears the mode and tracker. The power-on reset also clears the lock.
module otp_overlay_ctrl
    import otp_ovl_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int WIN_AW    = 15,
    parameter int OTP_WORDS = 128,
    parameter bit TOP_BOOT  = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         por_n,
    input  logic                         cmd_we,
    input  logic [10:0]                  cmd_addr,
    input  logic [7:0]                   cmd_data,
    input  logic [ADDR_W-1:0]            acc_addr,
    input  logic                         acc_prog,
    output logic                         sel_main,
    output logic                         sel_otp,
    output logic [$clog2(OTP_WORDS)-1:0] map_addr,
    output logic                         prog_ok,
    output logic                         lock_q
);

    ovl_op_t op;
    logic    seq_rst_n;
    logic    secure_q;

    // Purpose: the tracker restarts on either reset.
    assign seq_rst_n = rst_n && por_n;

    otp_cmd_seq u_seq (
        .clk    (clk),
        .srst_n (seq_rst_n),
        .we     (cmd_we),
        .addr   (cmd_addr),
        .data   (cmd_data),
        .op     (op)
    );

    otp_mode_lock u_mode (
        .clk      (clk),
        .hw_rst_n (rst_n),
        .por_n    (por_n),
        .op       (op),
        .secure_q (secure_q),
        .lock_q   (lock_q)
    );

    otp_addr_map #(
        .ADDR_W    (ADDR_W),
        .WIN_AW    (WIN_AW),
        .OTP_WORDS (OTP_WORDS),
        .TOP_BOOT  (TOP_BOOT)
    ) u_map (
        .secure   (secure_q),
        .locked   (lock_q),
        .acc_addr (acc_addr),
        .acc_prog (acc_prog),
        .sel_main (sel_main),
        .sel_otp  (sel_otp),
        .map_addr (map_addr),
        .prog_ok  (prog_ok)
    );

    p_sel_excl_r4: assert property (@(posedge clk) disable iff (!seq_rst_n)
        $onehot0({sel_main, sel_otp}));

    p_secure_no_main_r5: assert property (@(posedge clk) disable iff (!seq_rst_n)
        secure_q |-> !sel_main);

    p_locked_no_prog_r8: assert property (@(posedge clk) disable iff (!seq_rst_n)
        (sel_otp && lock_q) |-> !prog_ok);

    p_por_clears_lock_r10: assert property (@(posedge clk)
        !por_n |=> !lock_q);

endmodule

// File: tb/otp_overlay_ctrl_bench.sv
module otp_overlay_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [10:0] cmd_addr = '0;
    logic [7:0]  cmd_data = '0;
    logic [19:0] acc_addr = '0;
    logic        acc_prog = 1'b0;

    logic        t_main, t_otp, t_prog, t_lock;
    logic [6:0]  t_map;
    logic        b_main, b_otp, b_prog, b_lock;
    logic [6:0]  b_map;

    int checks = 0;
    int fails  = 0;
    bit live   = 1'b0;

    // reference model state
    int m_step = 0;
    bit m_sec  = 1'b0;
    bit m_lock = 1'b0;

    always #10 clk = ~clk;

    otp_overlay_ctrl #(.TOP_BOOT(1'b1)) u_otp_overlay_ctrl (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .cmd_we(cmd_we),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .acc_addr(acc_addr),
        .acc_prog(acc_prog), .sel_main(t_main), .sel_otp(t_otp),
        .map_addr(t_map), .prog_ok(t_prog), .lock_q(t_lock));

    otp_overlay_ctrl #(.TOP_BOOT(1'b0)) u_otp_overlay_ctrl_bot (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .cmd_we(cmd_we),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .acc_addr(acc_addr),
        .acc_prog(acc_prog), .sel_main(b_main), .sel_otp(b_otp),
        .map_addr(b_map), .prog_ok(b_prog), .lock_q(b_lock));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // behavioural expectation for one configuration
    task automatic expect_out(input bit top, output bit e_main, output bit e_otp,
                              output int e_map, output bit e_prog, output string tag);
        bit win, otp;
        win = top ? (acc_addr >= 20'hF8000) : (acc_addr < 20'h08000);
        otp = win && ((acc_addr % 32768) < 128);
        if (!m_sec) begin
            e_main = 1; e_otp = 0; e_map = 0; e_prog = acc_prog; tag = "R6";
        end else if (otp) begin
            e_main = 0; e_otp = 1; e_map = acc_addr % 128;
            e_prog = acc_prog && !m_lock; tag = "R4/R8/R11";
        end else begin
            e_main = 0; e_otp = 0; e_map = 0; e_prog = 0; tag = "R5/R11";
        end
    endtask

    task automatic cmp_all();
        bit em, eo, ep; int ea; string tg;
        expect_out(1'b1, em, eo, ea, ep, tg);
        chk({tg, " top sel_main"}, t_main, em);
        chk({tg, " top sel_otp"}, t_otp, eo);
        chk({tg, " top map_addr"}, t_map, ea);
        chk({tg, " top prog_ok"}, t_prog, ep);
        chk("R7 top lock_q", t_lock, m_lock);
        expect_out(1'b0, em, eo, ea, ep, tg);
        chk({tg, " bot sel_main"}, b_main, em);
        chk({tg, " bot sel_otp"}, b_otp, eo);
        chk({tg, " bot map_addr"}, b_map, ea);
        chk({tg, " bot prog_ok"}, b_prog, ep);
        chk("R7 bot lock_q", b_lock, m_lock);
    endtask

    // model steps at every rising edge
    always @(posedge clk) begin
        if (!por_n) begin
            m_step = 0; m_sec = 0; m_lock = 0;
        end else if (!rst_n) begin
            m_step = 0; m_sec = 0;
        end else if (cmd_we) begin
            if (m_step == 0)
                m_step = (cmd_addr == 11'h555 && cmd_data == 8'hAA) ? 1 : 0;
            else if (m_step == 1)
                m_step = (cmd_addr == 11'h2AA && cmd_data == 8'h55) ? 2 : 0;
            else begin
                m_step = 0;
                if (cmd_data == 8'h88) m_sec = 1;
                else if (cmd_data == 8'h90) m_sec = 0;
                else if (cmd_data == 8'h60 && m_sec) m_lock = 1;
            end
        end
    end

    // per-cycle comparison after the edge has settled
    always @(posedge clk) begin
        #5;
        if (live) cmp_all();
    end

    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        cmd_we = 1'b1; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic cmd3(input logic [7:0] code);
        wr(11'h555, 8'hAA);
        wr(11'h2AA, 8'h55);
        wr(11'h123, code);
    endtask

    task automatic access(input logic [19:0] a, input logic p);
        @(negedge clk);
        acc_addr = a; acc_prog = p;
        #2;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        live = 1'b1;
        // reset state
        #2;
        chk("R10 reset sel_main", t_main, 1);
        chk("R10 reset lock_q", t_lock, 0);
        @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;

        access(20'hF8010, 1'b1);
        chk("R6 normal main", t_main, 1);
        chk("R6 normal prog", t_prog, 1);

        cmd3(8'h60);
        chk("R7 lock ignored outside secure", t_lock, 0);

        cmd3(8'h88);
        access(20'hF8005, 1'b1);
        chk("R1 enter otp sel", t_otp, 1);
        chk("R4 map addr", t_map, 5);
        chk("R8 prog before lock", t_prog, 1);
        chk("R11 bottom ignores top window", b_otp, 0);
        access(20'h0007F, 1'b0);
        chk("R11 bottom window otp", b_otp, 1);
        chk("R11 bottom map", b_map, 7'h7F);
        chk("R11 top not selected", t_otp, 0);
        access(20'hF8080, 1'b1);
        chk("R5 beyond otp words", t_otp, 0);
        chk("R5 no prog", t_prog, 0);

        // broken sequence, then bare code
        wr(11'h555, 8'hAA);
        wr(11'h2AA, 8'h12);
        wr(11'h555, 8'h90);
        access(20'hFFF80 & 20'hF807F, 1'b0);
        chk("R3 abort keeps secure", t_main, 0);
        // address match uses only 11 bits: 0x555 with upper bits set was sent by port width

        cmd3(8'h60);
        access(20'hF8001, 1'b1);
        chk("R7 lock set", t_lock, 1);
        chk("R8 prog refused when locked", t_prog, 0);

        // hardware reset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #2;
        chk("R9 hw reset exits secure", t_main, 1);
        chk("R9 hw reset keeps lock", t_lock, 1);

        // partial sequence cut by hardware reset
        wr(11'h555, 8'hAA);
        wr(11'h2AA, 8'h55);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        wr(11'h000, 8'h88);
        #2;
        chk("R9 partial sequence cleared", t_main, 1);

        cmd3(8'h88);
        #2;
        chk("R1 re-enter", t_main, 0);
        cmd3(8'h90);
        #2;
        chk("R2 exit", t_main, 1);

        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        #2;
        chk("R10 por clears lock", t_lock, 0);

        cmd3(8'h88);
        access(20'hF8002, 1'b1);
        chk("R10 lock gone, prog allowed", t_prog, 1);

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule